// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM Model

This block is a synthesizable behavioural model of a synchronous SRAM that moves two words on every access, one on each half of the clock. Commands, the address and the first write word are taken on the rising edge of the input clock `k`. The second write word is taken on the rising edge of its complement `k_n`. Read data leaves on the rising edges of a separate output clock pair `c`/`c_n`. When both output clocks are held high, the model falls back to a single-clock mode and launches read data from `k`/`k_n` instead.

A small word array sits inside. Every write word carries its own active-low lane mask. The lowest address bit sets the burst order. Echo clocks run all the time, so a receiver can use them to capture the data. In place of a tri-state bus the model drives `q_valid`, which is high while a real read beat is on `q`. At all other times `q` is zero.

Command-side state machine, clocked by `k`, with states `OP_IDLE`, `OP_READ` and `OP_WRITE`. At each rising `k` it moves to `OP_WRITE` when `ld_n`=0 and `rw`=0. It moves to `OP_READ` when `ld_n`=0 and `rw`=1. It moves to `OP_IDLE` when `ld_n`=1, from any state. While it sits in `OP_WRITE`, the array commits the write at the next `k` edge. Leaving `OP_READ` launches the read one `k` cycle later.

Output side, with two one-bit phase machines:
- The negative-edge machine moves to `BEAT_LEAD` at an output-negative edge when a read is launched, and to `BEAT_IDLE` otherwise.
- The positive-edge machine moves to `BEAT_TRAIL` at an output-positive edge when the negative machine is in `BEAT_LEAD`, and to `BEAT_IDLE` otherwise.

Top module: `ddr_b2_sram`

## Requirements
- R1: At a rising `k` with `ld_n`=0, a new operation starts: a read when `rw`=1, a write when `rw`=0.
- R2: At a rising `k` with `ld_n`=1, no operation starts and `rw` is ignored. A read already started still delivers both of its beats.
- R3: Every access moves exactly two words. `addr` is sampled only at the rising `k` of the command, so changing it afterwards has no effect.
- R4: Write beat one (data and `bw_n`) is sampled at the command's rising `k`. Write beat two is sampled at the next rising `k_n`.
- R5: `bw_n` is active low, with one bit per 9-bit lane: lane i is bits 9i+8..9i. A lane whose bit is 1 keeps its stored value.
- R6: `addr[ADDR_W-1:1]` selects a word pair. When `addr[0]`=0, beat one maps to word 0 and beat two to word 1. When `addr[0]`=1, beat one maps to word 1 and beat two to word 0. This applies to reads and writes alike.
- R7: For a read issued at rising `k` time t, with clock period T:
  - beat one is valid from the output-negative rising edge at t+1.5T;
  - beat two is valid from the output-positive rising edge at t+2T, until t+2.5T;
  - `q_valid` is 0 whenever no read beat is due.
- R8: When `c` and `c_n` are both 1, read beats and echo clocks follow `k`/`k_n` with the same latency.
- R9: `cq` follows the active positive output clock and `cq_n` the negative one. Both keep toggling while the bus is idle.
- R10: A read issued on the cycle right after a write to the same pair returns the newly merged data.
- R11: While `rst_n` is low, and after reset until a read is due, `q_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| k | input | 1 | Input clock, positive |
| k_n | input | 1 | Input clock, complement |
| c | input | 1 | Output clock, positive |
| c_n | input | 1 | Output clock, complement |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_n | input | 1 | Load control, low starts an access |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Word address; bit 0 sets burst order |
| d | input | LANES*LANE_W | Write data |
| bw_n | input | LANES | Lane write selects, active low |
| q | output | LANES*LANE_W | Read data, zero when idle |
| q_valid | output | 1 | Read beat present on `q` |
| cq | output | 1 | Echo clock, positive |
| cq_n | output | 1 | Echo clock, negative |

## Verification
The hardest case to reach is a write whose two beats carry different lane masks, with a read of the same pair on the very next cycle. Hitting it needs a second mask to be presented half a cycle after the command, and the read must overlap the commit edge. The bench produces this with a sweep over all sixteen masks. Each write uses mask m on beat one and its complement on beat two, is followed at once by a read of the same address, and then by a read of the partner word. Deselected cycles with garbage `rw` and data are interleaved, and the address is scrambled after every edge.

// File: rtl/ddr_b2_pkg.sv
`timescale 1ns/1ps
package ddr_b2_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        BEAT_IDLE  = 2'd0,
        BEAT_LEAD  = 2'd1,
        BEAT_TRAIL = 2'd2
    } beat_e;
endpackage

// File: rtl/ddr_b2_cmd.sv
`timescale 1ns/1ps
module ddr_b2_cmd
    import ddr_b2_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW     = LANES * LANE_W,
    localparam int PAIR_W = ADDR_W - 1
) (
    input  logic                     k,
    input  logic                     k_n,
    input  logic                     rst_n,
    input  logic                     ld_n,
    input  logic                     rw,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DW-1:0]            d,
    input  logic [LANES-1:0]         bw_n,
    output logic                     wr_commit,
    output logic [PAIR_W-1:0]        wr_pair,
    output logic [1:0][DW-1:0]       wr_data,
    output logic [1:0][LANES-1:0]    wr_en,
    output logic                     rd_go,
    output logic [PAIR_W-1:0]        rd_pair,
    output logic                     rd_swap
);
    op_e                st_q, st_d;
    logic [PAIR_W-1:0]  cmd_pair;
    logic               cmd_swap;
    logic [DW-1:0]      beat_a_d, beat_b_d;
    logic [LANES-1:0]   beat_a_m, beat_b_m;
    logic               rd_go_q, rd_swap_q;
    logic [PAIR_W-1:0]  rd_pair_q;

    // next-state decode of the command pins
    always_comb begin
        unique case ({ld_n, rw})
            2'b00:   st_d = OP_WRITE;
            2'b01:   st_d = OP_READ;
            default: st_d = OP_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge k or negedge rst_n) begin
        if (!rst_n) st_q <= OP_IDLE;
        else        st_q <= st_d;
    end

    // command, beat-one and read-launch capture on k
    always_ff @(posedge k or negedge rst_n) begin
        if (!rst_n) begin
            cmd_pair  <= '0;
            cmd_swap  <= 1'b0;
            beat_a_d  <= '0;
            beat_a_m  <= '1;
            rd_go_q   <= 1'b0;
            rd_pair_q <= '0;
            rd_swap_q <= 1'b0;
        end else begin
            if (!ld_n) begin
                cmd_pair <= addr[ADDR_W-1:1];
                cmd_swap <= addr[0];
            end
            beat_a_d  <= d;
            beat_a_m  <= bw_n;
            rd_go_q   <= (st_q == OP_READ);
            rd_pair_q <= cmd_pair;
            rd_swap_q <= cmd_swap;
        end
    end

    // beat-two capture on k_n
    always_ff @(posedge k_n or negedge rst_n) begin
        if (!rst_n) begin
            beat_b_d <= '0;
            beat_b_m <= '1;
        end else begin
            beat_b_d <= d;
            beat_b_m <= bw_n;
        end
    end

    // outputs derived from state
    always_comb begin
        wr_commit = 1'b0;
        unique case (st_q)
            OP_WRITE: wr_commit = 1'b1;
            default:  wr_commit = 1'b0;
        endcase
        wr_pair    = cmd_pair;
        wr_data[0] = cmd_swap ? beat_b_d : beat_a_d;
        wr_data[1] = cmd_swap ? beat_a_d : beat_b_d;
        wr_en[0]   = ~(cmd_swap ? beat_b_m : beat_a_m);
        wr_en[1]   = ~(cmd_swap ? beat_a_m : beat_b_m);
        rd_go      = rd_go_q;
        rd_pair    = rd_pair_q;
        rd_swap    = rd_swap_q;
    end

    assert_write_capture_R4: assert property (@(posedge k) disable iff (!rst_n)
        (!ld_n && !rw) |=> (wr_commit && wr_pair == $past(addr[ADDR_W-1:1])));

    assert_deselect_quiet_R2: assert property (@(posedge k) disable iff (!rst_n)
        ld_n |=> !wr_commit ##1 !rd_go);

    assert_read_launch_R1: assert property (@(posedge k) disable iff (!rst_n)
        (!ld_n && rw) |-> ##2 rd_go);
endmodule

// File: rtl/ddr_b2_array.sv
`timescale 1ns/1ps
module ddr_b2_array #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW     = LANES * LANE_W,
    localparam int PAIR_W = ADDR_W - 1,
    localparam int DEPTH  = 1 << PAIR_W
) (
    input  logic                  k,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [PAIR_W-1:0]     wr_pair,
    input  logic [1:0][DW-1:0]    wdat,
    input  logic [1:0][LANES-1:0] wen,
    input  logic [PAIR_W-1:0]     rd_pair,
    output logic [DW-1:0]         rd_w0,
    output logic [DW-1:0]         rd_w1
);
    logic [DW-1:0]     mem [DEPTH][2];
    logic [PAIR_W-1:0] last_pair;

    always_ff @(posedge k) begin
        if (we) begin
            for (int w = 0; w < 2; w++) begin
                for (int l = 0; l < LANES; l++) begin
                    if (wen[w][l])
                        mem[wr_pair][w][l*LANE_W +: LANE_W] <= wdat[w][l*LANE_W +: LANE_W];
                end
            end
        end
    end

    always_ff @(posedge k) last_pair <= wr_pair;

    assign rd_w0 = mem[rd_pair][0];
    assign rd_w1 = mem[rd_pair][1];

    for (genvar w = 0; w < 2; w++) begin : g_word
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assert_lane_write_R5: assert property (@(posedge k) disable iff (!rst_n)
                (we && wen[w][l]) |=>
                (mem[last_pair][w][l*LANE_W +: LANE_W] == $past(wdat[w][l*LANE_W +: LANE_W])));
            assert_lane_keep_R5: assert property (@(posedge k) disable iff (!rst_n)
                (we && !wen[w][l]) |=>
                (mem[last_pair][w][l*LANE_W +: LANE_W] == $past(mem[wr_pair][w][l*LANE_W +: LANE_W])));
        end
    end
endmodule

// File: rtl/ddr_b2_out.sv
`timescale 1ns/1ps
module ddr_b2_out
    import ddr_b2_pkg::*;
#(
    parameter int DW = 36
) (
    input  logic          oclk_p,
    input  logic          oclk_n,
    input  logic          rst_n,
    input  logic          rd_go,
    input  logic          rd_swap,
    input  logic [DW-1:0] rd_w0,
    input  logic [DW-1:0] rd_w1,
    output logic [DW-1:0] q,
    output logic          q_valid
);
    beat_e         n_st, p_st;
    logic [DW-1:0] n_first, n_second, p_word;

    // negative-phase state: beat one
    always_ff @(posedge oclk_n or negedge rst_n) begin
        if (!rst_n) begin
            n_st     <= BEAT_IDLE;
            n_first  <= '0;
            n_second <= '0;
        end else begin
            n_st     <= rd_go ? BEAT_LEAD : BEAT_IDLE;
            n_first  <= rd_swap ? rd_w1 : rd_w0;
            n_second <= rd_swap ? rd_w0 : rd_w1;
        end
    end

    // positive-phase state: beat two
    always_ff @(posedge oclk_p or negedge rst_n) begin
        if (!rst_n) begin
            p_st   <= BEAT_IDLE;
            p_word <= '0;
        end else begin
            p_st   <= (n_st == BEAT_LEAD) ? BEAT_TRAIL : BEAT_IDLE;
            p_word <= n_second;
        end
    end

    // the phase of the output clock selects which state drives the bus
    always_comb begin
        q       = '0;
        q_valid = 1'b0;
        if (oclk_p) begin
            unique case (p_st)
                BEAT_TRAIL: begin q = p_word;  q_valid = 1'b1; end
                default:    begin q = '0;      q_valid = 1'b0; end
            endcase
        end else begin
            unique case (n_st)
                BEAT_LEAD:  begin q = n_first; q_valid = 1'b1; end
                default:    begin q = '0;      q_valid = 1'b0; end
            endcase
        end
    end

    assert_two_beats_R7: assert property (@(posedge oclk_n) disable iff (!rst_n)
        rd_go |=> q_valid);
endmodule

// File: rtl/ddr_b2_sram.sv
`timescale 1ns/1ps
module ddr_b2_sram #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW     = LANES * LANE_W,
    localparam int PAIR_W = ADDR_W - 1
) (
    input  logic              k,
    input  logic              k_n,
    input  logic              c,
    input  logic              c_n,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     d,
    input  logic [LANES-1:0]  bw_n,
    output logic [DW-1:0]     q,
    output logic              q_valid,
    output logic              cq,
    output logic              cq_n
);
    logic                  single_clk, oclk_p, oclk_n;
    logic                  wr_commit, rd_go, rd_swap;
    logic [PAIR_W-1:0]     wr_pair, rd_pair;
    logic [1:0][DW-1:0]    wr_data;
    logic [1:0][LANES-1:0] wr_en;
    logic [DW-1:0]         rd_w0, rd_w1;

    assign single_clk = c & c_n;
    assign oclk_p     = single_clk ? k   : c;
    assign oclk_n     = single_clk ? k_n : c_n;
    assign cq         = oclk_p;
    assign cq_n       = oclk_n;

    ddr_b2_cmd #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_cmd (
        .k(k), .k_n(k_n), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
        .d(d), .bw_n(bw_n), .wr_commit(wr_commit), .wr_pair(wr_pair),
        .wr_data(wr_data), .wr_en(wr_en), .rd_go(rd_go), .rd_pair(rd_pair),
        .rd_swap(rd_swap)
    );

    ddr_b2_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .k(k), .rst_n(rst_n), .we(wr_commit), .wr_pair(wr_pair), .wdat(wr_data),
        .wen(wr_en), .rd_pair(rd_pair), .rd_w0(rd_w0), .rd_w1(rd_w1)
    );

    ddr_b2_out #(.DW(DW)) u_out (
        .oclk_p(oclk_p), .oclk_n(oclk_n), .rst_n(rst_n), .rd_go(rd_go),
        .rd_swap(rd_swap), .rd_w0(rd_w0), .rd_w1(rd_w1), .q(q), .q_valid(q_valid)
    );
endmodule

// File: tb/ddr_b2_sram_tb.sv
`timescale 1ns/1ps
module ddr_b2_sram_tb;
    logic        k = 1'b0, rst_n = 1'b0, single = 1'b0, ld_n = 1'b1, rw = 1'b0;
    logic        k_n, c, c_n;
    logic [3:0]  addr = '0;
    logic [35:0] d = '0;
    logic [3:0]  bw_n = '1;
    logic [35:0] q;
    logic        q_valid, cq, cq_n;

    int errors = 0, checks = 0, n = 0;
    bit done = 1'b0;
    logic [35:0] mdl [16];
    bit          exp_rd [2048];
    logic [35:0] exp_b1 [2048];
    logic [35:0] exp_b2 [2048];
    string       exp_tag [2048];

    always #10 k = ~k;   // 50 MHz
    assign k_n = ~k;
    assign c   = single ? 1'b1 : k;
    assign c_n = single ? 1'b1 : k_n;

    ddr_b2_sram u_dut (
        .k(k), .k_n(k_n), .c(c), .c_n(c_n), .rst_n(rst_n), .ld_n(ld_n), .rw(rw),
        .addr(addr), .d(d), .bw_n(bw_n), .q(q), .q_valid(q_valid), .cq(cq), .cq_n(cq_n)
    );

    function automatic logic [35:0] pat(int i);
        return 36'(i * 36'h10F1E2D3C + 36'h5A5A5A5A5);
    endfunction

    task automatic fail_if(bit bad, string req, string what, logic [35:0] act, logic [35:0] expv);
        checks++;
        if (bad) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic check_slot(int s, bit second);
        bit          ev = 1'b0;
        logic [35:0] ex = '0;
        string       t = "R7";
        if (s >= 0) begin
            ev = exp_rd[s];
            ex = second ? exp_b2[s] : exp_b1[s];
            t  = exp_tag[s];
        end
        fail_if(q_valid !== ev, t, second ? "valid beat2" : "valid beat1",
                {35'b0, q_valid}, {35'b0, ev});
        if (ev) fail_if(q !== ex, t, second ? "data beat2" : "data beat1", q, ex);
    endtask

    task automatic mdl_write(logic [3:0] a, logic [35:0] d0, logic [3:0] m0,
                             logic [35:0] d1, logic [3:0] m1);
        for (int l = 0; l < 4; l++) begin
            if (!m0[l]) mdl[a][l*9 +: 9]     = d0[l*9 +: 9];
            if (!m1[l]) mdl[a ^ 4'd1][l*9 +: 9] = d1[l*9 +: 9];
        end
    endtask

    // one k cycle: entered 5 ns before a rising k, left 5 ns before the next
    task automatic step(bit lo, bit rwv, logic [3:0] a, logic [35:0] d0, logic [3:0] m0,
                        logic [35:0] d1, logic [3:0] m1, string tag);
        ld_n = lo; rw = rwv; addr = a; d = d0; bw_n = m0;
        exp_rd[n]  = !lo && rwv;
        exp_b1[n]  = mdl[a];
        exp_b2[n]  = mdl[a ^ 4'd1];
        exp_tag[n] = tag;
        if (!lo && !rwv) mdl_write(a, d0, m0, d1, m1);
        @(posedge k);
        #5;
        addr = ~a; rw = ~rwv; d = d1; bw_n = m1;   // R3: late address change is ignored
        check_slot(n - 2, 1'b1);
        fail_if(cq !== 1'b1 || cq_n !== 1'b0, "R9", "echo high phase",
                {34'b0, cq, cq_n}, 36'h2);
        #10;
        check_slot(n - 1, 1'b0);
        fail_if(cq !== 1'b0 || cq_n !== 1'b1, "R9", "echo low phase",
                {34'b0, cq, cq_n}, 36'h1);
        n++;
    endtask

    task automatic idle(int cnt, string tag);
        for (int i = 0; i < cnt; i++) step(1'b1, i[0], 4'(i * 5), pat(900 + i), 4'h0, pat(950 + i), 4'h0, tag);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        // R11: reset holds the bus quiet
        repeat (3) begin
            @(posedge k); #5;
            fail_if(q_valid !== 1'b0, "R11", "valid in reset", {35'b0, q_valid}, 36'h0);
        end
        rst_n = 1'b1;
        @(posedge k); #15;
        fail_if(q_valid !== 1'b0, "R11", "valid after reset", {35'b0, q_valid}, 36'h0);

        // fill every pair with full masks, in-order bursts (R1, R4)
        for (int p = 0; p < 8; p++)
            step(1'b0, 1'b0, 4'(p * 2), pat(2 * p), 4'h0, pat(2 * p + 1), 4'h0, "R1");
        // read every address, both orders (R4, R6)
        for (int a = 0; a < 16; a++)
            step(1'b0, 1'b1, 4'(a), '0, 4'h0, '0, 4'h0, "R4 R6");
        idle(2, "R7");

        // mask sweep: beat one mask m, beat two mask ~m, then immediate read (R5, R10)
        for (int m = 0; m < 16; m++) begin
            step(1'b0, 1'b0, {3'(m % 8), m[3]}, pat(100 + m), 4'(m), pat(200 + m), ~4'(m), "R5");
            step(1'b0, 1'b1, {3'(m % 8), m[3]}, '0, 4'h0, '0, 4'h0, "R10");
            step(1'b0, 1'b1, {3'(m % 8), ~m[3]}, '0, 4'h0, '0, 4'h0, "R5");
        end
        idle(2, "R7");

        // deselected cycles with write-looking pins must change nothing (R2)
        for (int i = 0; i < 8; i++)
            step(1'b1, i[0], 4'(i * 2), pat(500 + i), 4'h0, pat(600 + i), 4'h0, "R2");
        // a read followed by deselects still completes (R2)
        step(1'b0, 1'b1, 4'd3, '0, 4'h0, '0, 4'h0, "R2");
        idle(3, "R2");
        for (int a = 0; a < 16; a++)
            step(1'b0, 1'b1, 4'(15 - a), '0, 4'h0, '0, 4'h0, "R2 R3");
        idle(2, "R7");

        // single-clock mode (R8)
        single = 1'b1;
        idle(2, "R8");
        step(1'b0, 1'b0, 4'd5, pat(700), 4'h5, pat(701), 4'hA, "R8");
        step(1'b0, 1'b1, 4'd5, '0, 4'h0, '0, 4'h0, "R8");
        for (int a = 0; a < 16; a++)
            step(1'b0, 1'b1, 4'(a ^ 6), '0, 4'h0, '0, 4'h0, "R8");
        idle(3, "R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        done = 1'b1;
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule